// File: doc/BRIEF.md
# Core Interrupt Pending and Request Gate

This block keeps the eight-bit interrupt-pending field of a processor core and decides, every cycle, whether the core should take an interrupt exception. Other logic sets or clears one pending line at a time by pulsing a strobe with a line index, or wipes the whole field with a single strobe. A built-in timer comparison also feeds the field: when the free-running count equals the compare value, and the count is not zero, a pending line picked by a three-bit selector is set.

The request decision takes the core's status fields: a global enable, an error-level flag, an exception-level flag and an eight-bit mask. The request is only possible while the enable is high and both level flags are low. Two qualifying tests are available through the parameter `MATCH_MODE`. In mode 0 the request needs some mask bit set and some pending bit set, in any positions. In mode 1 the request needs at least one bit set in both the mask and the pending field. The request comes from a two-state machine: `GATE_QUIET` moves to `GATE_RAISE` when the qualified condition is true, and `GATE_RAISE` falls back to `GATE_QUIET` when the condition is false. This makes the request a registered output.

Top module: `irq_pend_gate`

## Requirements
- R1: After reset, `pend_bits` is 0, and `pend_any`, `irq_req` and `line_err` are all 0.
- R2: A post strobe with line index n (0 to 7) sets only bit n of `pend_bits`. The change is visible after the next rising clock edge.
- R3: A clear strobe with line index n (0 to 7) resets only bit n. A clear and a post to the same line in the same cycle leave the bit cleared. A clear and a post to different lines both take effect.
- R4: A clear-all strobe sets all eight pending bits to 0. It overrides any post or clear in the same cycle.
- R5: A post or clear with a line index from 8 to 15 leaves `pend_bits` unchanged. It drives `line_err` to 1 for the cycle after the strobe.
- R6: `irq_req` is 0 whenever, in the previous cycle, the enable was 0, the error-level flag was 1 or the exception-level flag was 1.
- R7: With `MATCH_MODE` = 0 and the gate open, `irq_req` is 1 when the mask is nonzero and the pending field is nonzero, even if the two do not overlap.
- R8: With `MATCH_MODE` = 1 and the gate open, `irq_req` is 1 only when the bitwise AND of the mask and the pending field is nonzero.
- R9: A timer event occurs when `tmr_count` equals `tmr_compare` and `tmr_count` is not 0. A timer event sets bit `tmr_line` of the pending field. The timer set is applied after any clear or clear-all in the same cycle. Equal values of zero cause no event.
- R10: `pend_any` is 1 exactly when some bit of `pend_bits` is 1.
- R11: `irq_req` is registered. A change in the pending field, the mask or the status inputs reaches `irq_req` one clock later, and not in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_v | input | 1 | Post strobe |
| post_line | input | 4 | Line index for the post strobe |
| clr_v | input | 1 | Clear strobe |
| clr_line | input | 4 | Line index for the clear strobe |
| clr_all | input | 1 | Clear-all strobe |
| st_enable | input | 1 | Global interrupt enable |
| st_err_lvl | input | 1 | Error-level flag |
| st_exc_lvl | input | 1 | Exception-level flag |
| st_mask | input | 8 | Interrupt mask |
| tmr_count | input | 32 | Free-running count value |
| tmr_compare | input | 32 | Timer compare value |
| tmr_line | input | 3 | Pending line set by a timer event |
| pend_bits | output | 8 | Pending field |
| pend_any | output | 1 | Any pending bit set |
| irq_req | output | 1 | Interrupt request |
| line_err | output | 1 | Out-of-range line index seen in the previous cycle |

## Verification
The request logic is tried with four kinds of input:
- A mask that overlaps the pending field. This sets the request in both modes.
- A mask and pending field that are both nonzero but share no bit. This is the only pattern that separates mode 0 from mode 1.
- A zero mask and a cleared field. These rule out a decision that looks at only one operand.
- Each of the three status conditions raised alone. This shows that each one closes the gate on its own.

Same-cycle collisions check the priority order: a clear against a post, clear-all against a post, and a timer event against clear-all. Count and compare values that are equal at zero, and equal at a nonzero value, separate a correct timer test from a bare equality test.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
    localparam int unsigned LINES  = 8;
    localparam int unsigned IDX_W  = $clog2(LINES);
    localparam int unsigned LINE_W = IDX_W + 1;

    typedef logic [LINES-1:0] pend_t;

    typedef enum logic {
        GATE_QUIET = 1'b0,
        GATE_RAISE = 1'b1
    } gate_state_t;
endpackage

// File: rtl/irq_timer_match.sv
module irq_timer_match
    import irq_pend_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] compare_i,
    input  logic [IDX_W-1:0] line_i,
    output logic             hit_o,
    output pend_t            set_mask_o
);
    // An event needs equal values and a count that is not zero.
    assign hit_o = (count_i == compare_i) && (|count_i);

    // Decode the selected line into a one-hot set mask.
    for (genvar g = 0; g < LINES; g++) begin : g_dec
        assign set_mask_o[g] = hit_o && (line_i == IDX_W'(g));
    end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
    import irq_pend_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_v,
    input  logic [LINE_W-1:0] post_line,
    input  logic              clr_v,
    input  logic [LINE_W-1:0] clr_line,
    input  logic              clr_all,
    input  pend_t             tmr_set,
    output pend_t             pend_q,
    output logic              err_q
);
    logic  post_ok, clr_ok;
    pend_t pend_d;
    logic  err_d;

    assign post_ok = post_v && (post_line < LINE_W'(LINES));
    assign clr_ok  = clr_v  && (clr_line  < LINE_W'(LINES));

    // Apply in priority order: post, then clear, then clear-all, then timer.
    always_comb begin
        pend_d = pend_q;
        if (post_ok) pend_d[post_line[IDX_W-1:0]] = 1'b1;
        if (clr_ok)  pend_d[clr_line[IDX_W-1:0]]  = 1'b0;
        if (clr_all) pend_d = '0;
        pend_d = pend_d | tmr_set;
        err_d  = (post_v && !post_ok) || (clr_v && !clr_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            err_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            err_q  <= err_d;
        end
    end

    a_r5_bad_index_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (post_v && !post_ok && !clr_v && !clr_all && tmr_set == '0)
        |=> (pend_q == $past(pend_q)) && err_q);

    a_r4_clear_all_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && tmr_set == '0) |=> (pend_q == '0));

    a_r2_post_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (post_ok && !clr_all && !(clr_ok && clr_line == post_line))
        |=> pend_q[$past(post_line[IDX_W-1:0])]);

    a_r3_clear_resets_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ok && tmr_set == '0) |=> !pend_q[$past(clr_line[IDX_W-1:0])]);
endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import irq_pend_pkg::*;
#(
    parameter bit MATCH_MODE = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  enable_i,
    input  logic  err_lvl_i,
    input  logic  exc_lvl_i,
    input  pend_t mask_i,
    input  pend_t pend_i,
    output logic  req_o
);
    gate_state_t state_q, state_d;
    logic        open_w, qual_w;

    assign open_w = enable_i && !err_lvl_i && !exc_lvl_i;

    if (MATCH_MODE) begin : g_bitwise
        assign qual_w = |(mask_i & pend_i);
    end else begin : g_anynz
        assign qual_w = (|mask_i) && (|pend_i);
    end

    always_comb begin
        unique case (state_q)
            GATE_QUIET: state_d = (open_w && qual_w) ? GATE_RAISE : GATE_QUIET;
            GATE_RAISE: state_d = (open_w && qual_w) ? GATE_RAISE : GATE_QUIET;
            default:    state_d = GATE_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GATE_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        req_o = (state_q == GATE_RAISE);
    end

    a_r6_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !open_w |=> !req_o);

    a_r8_no_overlap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (MATCH_MODE && (mask_i & pend_i) == '0) |=> !req_o);

    a_r7_any_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (!MATCH_MODE && open_w && (|mask_i) && (|pend_i)) |=> req_o);
endmodule

// File: rtl/irq_pend_gate.sv
module irq_pend_gate
    import irq_pend_pkg::*;
#(
    parameter int unsigned CNT_W      = 32,
    parameter bit          MATCH_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_v,
    input  logic [LINE_W-1:0] post_line,
    input  logic              clr_v,
    input  logic [LINE_W-1:0] clr_line,
    input  logic              clr_all,
    input  logic              st_enable,
    input  logic              st_err_lvl,
    input  logic              st_exc_lvl,
    input  logic [LINES-1:0]  st_mask,
    input  logic [CNT_W-1:0]  tmr_count,
    input  logic [CNT_W-1:0]  tmr_compare,
    input  logic [IDX_W-1:0]  tmr_line,
    output logic [LINES-1:0]  pend_bits,
    output logic              pend_any,
    output logic              irq_req,
    output logic              line_err
);
    logic  tmr_hit;
    pend_t tmr_set;
    pend_t pend_q;

    irq_timer_match #(.CNT_W(CNT_W)) u_tmr (
        .count_i    (tmr_count),
        .compare_i  (tmr_compare),
        .line_i     (tmr_line),
        .hit_o      (tmr_hit),
        .set_mask_o (tmr_set)
    );

    irq_pend_reg u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .post_v    (post_v),
        .post_line (post_line),
        .clr_v     (clr_v),
        .clr_line  (clr_line),
        .clr_all   (clr_all),
        .tmr_set   (tmr_set),
        .pend_q    (pend_q),
        .err_q     (line_err)
    );

    irq_gate #(.MATCH_MODE(MATCH_MODE)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (st_enable),
        .err_lvl_i (st_err_lvl),
        .exc_lvl_i (st_exc_lvl),
        .mask_i    (st_mask),
        .pend_i    (pend_q),
        .req_o     (irq_req)
    );

    assign pend_bits = pend_q;
    assign pend_any  = |pend_q;

    a_r9_timer_sets_line: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_hit |=> pend_bits[$past(tmr_line)]);

    a_r9_zero_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_count == '0) |-> !tmr_hit);

    a_r10_any_flag: assert property (@(posedge clk) disable iff (!rst_n)
        pend_any == (pend_bits != '0));
endmodule

// File: tb/irq_pend_gate_test.sv
module irq_pend_gate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        post_v = 0, clr_v = 0, clr_all = 0;
    logic [3:0]  post_line = 0, clr_line = 0;
    logic        st_enable = 0, st_err_lvl = 0, st_exc_lvl = 0;
    logic [7:0]  st_mask = 0;
    logic [31:0] tmr_count = 0, tmr_compare = 0;
    logic [2:0]  tmr_line = 0;
    logic [7:0]  pend_bits, pend_bits_b;
    logic        pend_any, pend_any_b, irq_req, irq_req_b, line_err, line_err_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_pend_gate #(.MATCH_MODE(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .post_v(post_v), .post_line(post_line),
        .clr_v(clr_v), .clr_line(clr_line), .clr_all(clr_all),
        .st_enable(st_enable), .st_err_lvl(st_err_lvl), .st_exc_lvl(st_exc_lvl),
        .st_mask(st_mask), .tmr_count(tmr_count), .tmr_compare(tmr_compare),
        .tmr_line(tmr_line), .pend_bits(pend_bits), .pend_any(pend_any),
        .irq_req(irq_req), .line_err(line_err));

    irq_pend_gate #(.MATCH_MODE(1'b1)) uut_bw (
        .clk(clk), .rst_n(rst_n), .post_v(post_v), .post_line(post_line),
        .clr_v(clr_v), .clr_line(clr_line), .clr_all(clr_all),
        .st_enable(st_enable), .st_err_lvl(st_err_lvl), .st_exc_lvl(st_exc_lvl),
        .st_mask(st_mask), .tmr_count(tmr_count), .tmr_compare(tmr_compare),
        .tmr_line(tmr_line), .pend_bits(pend_bits_b), .pend_any(pend_any_b),
        .irq_req(irq_req_b), .line_err(line_err_b));

    typedef struct packed {
        logic       pv;  logic [3:0] pl;
        logic       cv;  logic [3:0] cl;
        logic       ca;
        logic       en;  logic erl; logic exl;
        logic [7:0] mask;
        logic [7:0] exp_pend;
        logic       exp_any_req;
        logic       exp_bw_req;
        logic       exp_err;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1,4'd3, 1'b0,4'd0, 1'b0, 1'b1,1'b0,1'b0, 8'h08, 8'h08, 1'b1,1'b1,1'b0}, // R2 R8 overlap
        '{1'b1,4'd5, 1'b0,4'd0, 1'b0, 1'b1,1'b0,1'b0, 8'h01, 8'h28, 1'b1,1'b0,1'b0}, // R7 R8 disjoint
        '{1'b0,4'd0, 1'b1,4'd3, 1'b0, 1'b1,1'b0,1'b0, 8'h01, 8'h20, 1'b1,1'b0,1'b0}, // R3 clear one
        '{1'b1,4'd9, 1'b0,4'd0, 1'b0, 1'b1,1'b0,1'b0, 8'h20, 8'h20, 1'b1,1'b1,1'b1}, // R5 bad post
        '{1'b0,4'd0, 1'b1,4'd12,1'b0, 1'b1,1'b0,1'b0, 8'h20, 8'h20, 1'b1,1'b1,1'b1}, // R5 bad clear
        '{1'b1,4'd2, 1'b1,4'd2, 1'b0, 1'b1,1'b0,1'b0, 8'hFF, 8'h20, 1'b1,1'b1,1'b0}, // R3 clear wins
        '{1'b1,4'd0, 1'b1,4'd5, 1'b0, 1'b1,1'b0,1'b0, 8'h01, 8'h01, 1'b1,1'b1,1'b0}, // R3 both lines
        '{1'b0,4'd0, 1'b0,4'd0, 1'b0, 1'b0,1'b0,1'b0, 8'hFF, 8'h01, 1'b0,1'b0,1'b0}, // R6 enable off
        '{1'b0,4'd0, 1'b0,4'd0, 1'b0, 1'b1,1'b1,1'b0, 8'hFF, 8'h01, 1'b0,1'b0,1'b0}, // R6 error level
        '{1'b0,4'd0, 1'b0,4'd0, 1'b0, 1'b1,1'b0,1'b1, 8'hFF, 8'h01, 1'b0,1'b0,1'b0}, // R6 exception level
        '{1'b0,4'd0, 1'b0,4'd0, 1'b0, 1'b1,1'b0,1'b0, 8'h00, 8'h01, 1'b0,1'b0,1'b0}, // R7 zero mask
        '{1'b1,4'd7, 1'b0,4'd0, 1'b1, 1'b1,1'b0,1'b0, 8'hFF, 8'h00, 1'b0,1'b0,1'b0}, // R4 clear-all wins
        '{1'b1,4'd7, 1'b0,4'd0, 1'b0, 1'b1,1'b0,1'b0, 8'h80, 8'h80, 1'b1,1'b1,1'b0}, // R2 top line
        '{1'b1,4'd1, 1'b0,4'd0, 1'b0, 1'b1,1'b0,1'b0, 8'h02, 8'h82, 1'b1,1'b1,1'b0}  // R2 R8
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_ops();
        post_v = 0; clr_v = 0; clr_all = 0; post_line = 0; clr_line = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pend", pend_bits, 8'h00);
        chk("R1 any", pend_any, 1'b0);
        chk("R1 req", irq_req, 1'b0);
        chk("R1 err", line_err, 1'b0);

        for (int i = 0; i < NV; i++) begin
            post_v = VECS[i].pv; post_line = VECS[i].pl;
            clr_v = VECS[i].cv; clr_line = VECS[i].cl; clr_all = VECS[i].ca;
            st_enable = VECS[i].en; st_err_lvl = VECS[i].erl; st_exc_lvl = VECS[i].exl;
            st_mask = VECS[i].mask;
            @(negedge clk);
            idle_ops();
            chk($sformatf("R2/R3/R4/R5 vec%0d pend", i), pend_bits, VECS[i].exp_pend);
            chk($sformatf("R10 vec%0d any", i), pend_any, |VECS[i].exp_pend);
            chk($sformatf("R5 vec%0d err", i), line_err, VECS[i].exp_err);
            @(negedge clk);
            chk($sformatf("R6/R7 vec%0d req", i), irq_req, VECS[i].exp_any_req);
            chk($sformatf("R8 vec%0d req", i), irq_req_b, VECS[i].exp_bw_req);
            chk($sformatf("R5 vec%0d err drop", i), line_err, 1'b0);
        end

        // R11: pend=0x82, mask=0x02, request high; remove mask, output waits one edge
        st_mask = 8'h00;
        #1;
        chk("R11 same cycle", irq_req, 1'b1);
        @(negedge clk);
        chk("R11 next cycle", irq_req, 1'b0);

        // R9: zero count equal to zero compare is not an event
        clr_all = 1; @(negedge clk); idle_ops();
        tmr_count = 0; tmr_compare = 0; tmr_line = 3'd4;
        @(negedge clk);
        chk("R9 zero no event", pend_bits, 8'h00);

        // R9: nonzero match sets selected line
        tmr_count = 32'd5; tmr_compare = 32'd5; tmr_line = 3'd6;
        @(negedge clk);
        tmr_count = 32'd6;
        chk("R9 timer sets line", pend_bits, 8'h40);

        // R9: timer set survives a same-cycle clear-all
        tmr_count = 32'd9; tmr_compare = 32'd9; tmr_line = 3'd1; clr_all = 1;
        @(negedge clk);
        idle_ops(); tmr_count = 32'd10;
        chk("R9 timer after clear-all", pend_bits, 8'h02);

        // R9: timer set survives a same-cycle clear of that line
        tmr_count = 32'd11; tmr_compare = 32'd11; tmr_line = 3'd2;
        clr_v = 1; clr_line = 4'd2;
        @(negedge clk);
        idle_ops(); tmr_count = 32'd12;
        chk("R9 timer after clear", pend_bits, 8'h06);

        // R1: reset again clears everything
        rst_n = 0; @(negedge clk); rst_n = 1;
        chk("R1 reset pend", pend_bits, 8'h00);
        chk("R1 reset req", irq_req, 1'b0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule